// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

This block is a very small 8-bit processor built around one shared data bus. A 16-word by 8-bit memory holds both the program and its operands. A one-hot ring of six states steps every instruction through three fetch cycles and three execute cycles. In each cycle a 12-bit control word selects the single unit that drives the bus and the registers that load from it. The arithmetic path is a combinational two's-complement adder-subtractor. It takes the accumulator and a second operand register as inputs. The only visible result is an 8-bit output register that drives a row of LEDs.

A program is entered from front-panel inputs. While `prog_mode` is high, the memory address comes straight from `addr_sw`, and each clock edge with `wr_strobe` high stores `data_sw` at that address. When `prog_mode` goes low, execution starts from address 0 and the memory address comes from the internal address register instead. Five instructions exist: load, add, subtract, output and halt. After a halt, execution stays frozen until reset.

Top module: `acc_cpu8`

## Requirements
- R1: A synchronous active-low reset clears the output register, program counter, ring state, halt flag and every data register. After reset is released in run mode, execution restarts at address 0. Memory contents survive reset.
- R2: While `prog_mode` is high, a rising edge with `wr_strobe` high writes `data_sw` into the word at `addr_sw`. While `prog_mode` is high, the ring counter, program counter and all registers hold their values. Execution resumes exactly where it paused when `prog_mode` returns low.
- R3: While `prog_mode` is low, `wr_strobe`, `addr_sw` and `data_sw` have no effect on memory.
- R4: Every instruction takes exactly six clock edges. If instruction i (counting from 0) is an output instruction, `led_out` changes on edge 6i+4 after `prog_mode` falls, and at no other edge.
- R5: An instruction word carries the opcode in bits 7:4 and an operand address in bits 3:0. Load (opcode 0000) copies the addressed memory word into the accumulator.
- R6: Add (opcode 0001) replaces the accumulator with the accumulator plus the addressed word, modulo 256.
- R7: Subtract (opcode 0010) replaces the accumulator with the accumulator minus the addressed word, modulo 256. It is formed as an addition of the inverted operand with a carry-in of 1.
- R8: Output (opcode 1110) copies the accumulator into the output register. Halt (opcode 1111) stops all further state changes until reset, so later instructions in memory never run.
- R9: Any other opcode does nothing for its six cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_mode | input | 1 | 1 = program entry with execution paused, 0 = run |
| addr_sw | input | 4 | Memory address used during program entry |
| data_sw | input | 8 | Word written during program entry |
| wr_strobe | input | 1 | Write enable for program entry |
| led_out | output | 8 | Output register driving the LEDs |

## Verification
The main test is a program that loads, adds, outputs, subtracts, outputs and halts. It is run over a grid of 64 operand triples. The triples include 0, 1, 0x7F, 0x80, 0xFE and 0xFF, so wrap-around on add and on subtract is tried next to the ordinary cases. The LEDs are checked on the edge before and the edge of each output step, which separates a wrong result from a wrong cycle count. A word placed after the halt would overwrite the LEDs with 0xA5 if the halt failed. Separate programs cover a bare load, undefined opcodes (which would change the accumulator if decoded as loads), a write strobe during run, a program-mode pause and a mid-run reset.

// File: rtl/cpu8_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the single-bus processor: opcode codes, the
// length of the instruction ring and the 12-bit control word layout.
package cpu8_pkg;
    localparam int OPC_W = 4;
    localparam int STEPS = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_LDA = 4'h0,
        OP_ADD = 4'h1,
        OP_SUB = 4'h2,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } opcode_e;

    // One bit per bus driver or register action; drivers must be one-hot-or-zero.
    typedef struct packed {
        logic pc_inc;
        logic pc_drv;
        logic mar_ld;
        logic mem_drv;
        logic ir_ld;
        logic ir_drv;
        logic acc_ld;
        logic acc_drv;
        logic sub;
        logic alu_drv;
        logic b_ld;
        logic out_ld;
    } ctrl_word_t;
endpackage

// File: rtl/cpu8_alu.sv
`timescale 1ns/1ps
// Combinational two's-complement adder-subtractor.
// Assumes: sub selects a - b, formed as a + ~b + 1; result wraps modulo 2**DW.
module cpu8_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] y
);
    // Conditional inversion of b plus carry-in performs both operations.
    assign y = a + (b ^ {DW{sub}}) + DW'(sub);

    // Check the adder result against plain arithmetic (R6, R7).
    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            assert_alu_math_R7: assert (y == (sub ? DW'(a - b) : DW'(a + b)))
                else $error("adder-subtractor result mismatch");
        end
    end
endmodule

// File: rtl/cpu8_mem.sv
`timescale 1ns/1ps
// Program and data memory: asynchronous read, synchronous write.
// Assumes: the caller selects the address source; contents are not reset.
module cpu8_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store one word per enabled edge.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    // Read data follows the address with no clock.
    assign rdata = cells[addr];
endmodule

// File: rtl/cpu8_seq.sv
`timescale 1ns/1ps
// Controller-sequencer: a six-state one-hot ring plus opcode decode that
// produces the control word for the next rising edge.
// Assumes: run_en low pauses everything; a halt is sticky until reset.
module cpu8_seq
    import cpu8_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [OW-1:0] opcode,
    output ctrl_word_t    cw
);
    logic [STEPS-1:0] ring;
    logic             halted;
    logic             adv;
    logic             is_lda, is_add, is_sub, is_out, is_hlt;

    assign adv    = run_en && !halted;
    assign is_lda = (opcode == OW'(OP_LDA));
    assign is_add = (opcode == OW'(OP_ADD));
    assign is_sub = (opcode == OW'(OP_SUB));
    assign is_out = (opcode == OW'(OP_OUT));
    assign is_hlt = (opcode == OW'(OP_HLT));

    // Rotate the ring one state per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   ring <= STEPS'(1);
        else if (adv) ring <= {ring[STEPS-2:0], ring[STEPS-1]};
    end

    // Latch a halt on the first execute state of a halt instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)                        halted <= 1'b0;
        else if (adv && ring[3] && is_hlt) halted <= 1'b1;
    end

    // Decode ring state and opcode into the control word.
    always_comb begin
        cw = '0;
        if (adv) begin
            if (ring[0]) begin cw.pc_drv = 1'b1; cw.mar_ld = 1'b1; end
            if (ring[1]) cw.pc_inc = 1'b1;
            if (ring[2]) begin cw.mem_drv = 1'b1; cw.ir_ld = 1'b1; end
            if (ring[3]) begin
                if (is_lda || is_add || is_sub) begin cw.ir_drv = 1'b1; cw.mar_ld = 1'b1; end
                if (is_out) begin cw.acc_drv = 1'b1; cw.out_ld = 1'b1; end
            end
            if (ring[4]) begin
                if (is_lda) begin cw.mem_drv = 1'b1; cw.acc_ld = 1'b1; end
                if (is_add || is_sub) begin cw.mem_drv = 1'b1; cw.b_ld = 1'b1; end
            end
            if (ring[5] && (is_add || is_sub)) begin
                cw.alu_drv = 1'b1;
                cw.acc_ld  = 1'b1;
                cw.sub     = is_sub;
            end
        end
    end

    // Exactly one ring state is active after reset (R4).
    assert_ring_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ring) == 1);

    // A halt, once taken, holds until reset (R8).
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // A halted sequencer does not move its ring (R8).
    assert_halt_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(ring));
endmodule

// File: rtl/acc_cpu8.sv
`timescale 1ns/1ps
// Single-bus accumulator processor: datapath registers, bus multiplexer,
// front-panel address selection and instances of sequencer, ALU and memory.
// Assumes: DATA_W = 4 + ADDR_W so an instruction is opcode plus address.
module acc_cpu8
    import cpu8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic [ADDR_W-1:0] addr_sw,
    input  logic [DATA_W-1:0] data_sw,
    input  logic              wr_strobe,
    output logic [DATA_W-1:0] led_out
);
    localparam int OW = DATA_W - ADDR_W;

    ctrl_word_t        cw;
    logic [ADDR_W-1:0] pc, mar, mem_addr;
    logic [DATA_W-1:0] ir, acc, breg, outr;
    logic [DATA_W-1:0] bus, mem_q, alu_y;
    logic              mem_we;

    cpu8_seq #(.OW(OW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (!prog_mode),
        .opcode (ir[DATA_W-1:ADDR_W]),
        .cw     (cw)
    );

    cpu8_alu #(.DW(DATA_W)) u_alu (
        .a   (acc),
        .b   (breg),
        .sub (cw.sub),
        .y   (alu_y)
    );

    assign mem_addr = prog_mode ? addr_sw : mar;
    assign mem_we   = prog_mode && wr_strobe;

    cpu8_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (data_sw),
        .rdata (mem_q)
    );

    // Shared bus: the one enabled source, else zero.
    always_comb begin
        bus = '0;
        if (cw.pc_drv)  bus = DATA_W'(pc);
        if (cw.mem_drv) bus = mem_q;
        if (cw.ir_drv)  bus = DATA_W'(ir[ADDR_W-1:0]);
        if (cw.acc_drv) bus = acc;
        if (cw.alu_drv) bus = alu_y;
    end

    // Program counter: wraps from all ones to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         pc <= '0;
        else if (cw.pc_inc) pc <= pc + 1'b1;
    end

    // Memory address register: low bits of the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         mar <= '0;
        else if (cw.mar_ld) mar <= bus[ADDR_W-1:0];
    end

    // Instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n)        ir <= '0;
        else if (cw.ir_ld) ir <= bus;
    end

    // Accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc <= '0;
        else if (cw.acc_ld) acc <= bus;
    end

    // Second operand register.
    always_ff @(posedge clk) begin
        if (!rst_n)       breg <= '0;
        else if (cw.b_ld) breg <= bus;
    end

    // Output register feeding the LEDs.
    always_ff @(posedge clk) begin
        if (!rst_n)         outr <= '0;
        else if (cw.out_ld) outr <= bus;
    end

    assign led_out = outr;

    // At most one unit drives the bus in any cycle (R4).
    assert_one_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cw.pc_drv, cw.mem_drv, cw.ir_drv, cw.acc_drv, cw.alu_drv}));

    // The LEDs change only after an output load (R4, R8).
    assert_out_only_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(outr)) |-> $past(cw.out_ld));

    // Program mode freezes the program counter (R2).
    assert_prog_holds_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode |=> $stable(pc));
endmodule

// File: tb/test_acc_cpu8.sv
`timescale 1ns/1ps
// Self-checking bench: loads programs from the front panel, runs them and
// compares the LEDs against arithmetic computed here.
module test_acc_cpu8;
    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_mode = 1'b1;
    logic          wr_strobe = 1'b0;
    logic [AW-1:0] addr_sw = '0;
    logic [DW-1:0] data_sw = '0;
    logic [DW-1:0] led_out;

    int checks = 0;
    int failures = 0;
    int edge_n = 0;
    logic [DW-1:0] img [16];
    logic [DW-1:0] vals [8];

    always #10 clk = ~clk;

    acc_cpu8 #(.DATA_W(DW), .ADDR_W(AW)) i_acc_cpu8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_mode (prog_mode),
        .addr_sw   (addr_sw),
        .data_sw   (data_sw),
        .wr_strobe (wr_strobe),
        .led_out   (led_out)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: led_out=%02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        edge_n++;
    endtask

    task automatic run_to(input int n);
        while (edge_n < n) tick();
    endtask

    task automatic clear_img();
        for (int k = 0; k < 16; k++) img[k] = 8'h00;
    endtask

    // Reset, write the whole image from the panel, then enter run mode.
    task automatic load_and_start();
        rst_n = 1'b0;
        prog_mode = 1'b1;
        tick();
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) begin
            addr_sw = AW'(k);
            data_sw = img[k];
            wr_strobe = 1'b1;
            tick();
        end
        wr_strobe = 1'b0;
        prog_mode = 1'b0;
        edge_n = 0;
    endtask

    // LDA 12; ADD 13; OUT; SUB 14; OUT; HLT; LDA 15; OUT.
    task automatic build_main(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] c);
        clear_img();
        img[0] = 8'h0C; img[1] = 8'h1D; img[2] = 8'hE0; img[3] = 8'h2E;
        img[4] = 8'hE0; img[5] = 8'hF0; img[6] = 8'h0F; img[7] = 8'hE0;
        img[12] = a; img[13] = b; img[14] = c; img[15] = 8'hA5;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: led_out=%02h expected run completion", led_out);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] s1, s2;
        vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h02; vals[3] = 8'h7F;
        vals[4] = 8'h80; vals[5] = 8'hFE; vals[6] = 8'hFF; vals[7] = 8'h55;

        // R1: reset state
        tick();
        check("R1 reset clears output", led_out, 8'h00);

        // Main sweep over operand triples (R4, R6, R7, R8)
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                s1 = vals[i] + vals[j];
                s2 = s1 - vals[(i + 3 * j) % 8];
                build_main(vals[i], vals[j], vals[(i + 3 * j) % 8]);
                load_and_start();
                run_to(15);
                check("R4 no output before edge 16", led_out, 8'h00);
                run_to(16);
                check("R6 sum at edge 16", led_out, s1);
                run_to(27);
                check("R4 output held until edge 28", led_out, s1);
                run_to(28);
                check("R7 difference at edge 28", led_out, s2);
                run_to(60);
                check("R8 halt blocks later output", led_out, s2);
            end
        end

        // R5: bare load then output
        clear_img();
        img[0] = 8'h09; img[1] = 8'hE0; img[2] = 8'hF0; img[9] = 8'hC3;
        load_and_start();
        run_to(9);
        check("R5 output not yet loaded", led_out, 8'h00);
        run_to(10);
        check("R5 load from operand address", led_out, 8'hC3);

        // R9: undefined opcodes leave the accumulator untouched
        clear_img();
        img[0] = 8'h0C; img[1] = 8'h3D; img[2] = 8'h7D; img[3] = 8'hE0; img[4] = 8'hF0;
        img[12] = 8'h11; img[13] = 8'h99;
        load_and_start();
        run_to(22);
        check("R9 undefined opcodes are no-ops", led_out, 8'h11);

        // R3: write strobe during run does not alter memory
        build_main(8'h10, 8'h20, 8'h05);
        load_and_start();
        run_to(2);
        addr_sw = 4'd13;
        data_sw = 8'hFF;
        wr_strobe = 1'b1;
        tick();
        wr_strobe = 1'b0;
        run_to(16);
        check("R3 run-mode write ignored", led_out, 8'h30);

        // R2: program mode pauses just before the output edge
        build_main(8'h10, 8'h20, 8'h05);
        load_and_start();
        run_to(15);
        prog_mode = 1'b1;
        addr_sw = 4'd0;
        repeat (5) tick();
        check("R2 paused during program mode", led_out, 8'h00);
        prog_mode = 1'b0;
        tick();
        check("R2 resumes at paused state", led_out, 8'h30);

        // R1: mid-run reset clears output and restarts at address 0
        build_main(8'h03, 8'h04, 8'h01);
        load_and_start();
        run_to(20);
        check("R1 pre-reset output", led_out, 8'h07);
        rst_n = 1'b0;
        tick();
        check("R1 reset clears output mid-run", led_out, 8'h00);
        rst_n = 1'b1;
        edge_n = 0;
        run_to(16);
        check("R1 restart from address 0", led_out, 8'h07);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule